// File: doc/BRIEF.md
# Averaged power spectrum accumulator

This block sits behind a frequency transform in a spectrum-sensing receive path. It takes a stream of complex bins, one bin per accepted beat, and forms the power of each bin as the sum of the squared real and imaginary parts. The powers of the same bin are summed across several consecutive windows in an on-chip memory indexed by bin number. Once the last window of an averaging run has arrived, the block streams out one averaged value per bin. The values come out in ascending bin order, and a last flag marks the final bin.

The window length and the number of windows averaged are set at runtime as base-2 exponents. Both are powers of two, so the average needs no divider and reduces to a right shift of each sum. The settings are captured when the first bin of a run is accepted, and they hold until that run's output has been fully drained. The input stops accepting data while the output is draining. The next run starts once the final output bin has been taken.

Top module: `psd_avg_accum`

## Requirements
- R1: Each bin's power is re*re + im*im, where re and im are two's-complement signed DATA_W-bit values. The result is exact in 2*DATA_W+1 bits.
- R2: A window holds 2^pts_log2_i bins. Exponent values below MIN_PTS_LOG2 (6) act as 6, and values above MAX_PTS_LOG2 (10) act as 10.
- R3: A run averages 2^avg_log2_i windows, with the exponent clamped to at most MAX_AVG_LOG2 (4). Each output value is the per-bin sum shifted right by the effective exponent, which is the floor of the mean.
- R4: The first window of a run overwrites the stored sums, so nothing left from an earlier run enters the result.
- R5: After the final window, the output delivers every bin exactly once, in ascending order starting at bin 0. out_last_o is high only on the final bin.
- R6: Window length and average count are sampled on the cycle the first bin of a run is accepted. Later changes to pts_log2_i or avg_log2_i have no effect until the next run.
- R7: in_ready_o is high only while a run is accumulating, and out_valid_o is high only while the result is draining. The two are never high together.
- R8: While out_valid_o is high and out_ready_i is low, out_valid_o, out_data_o and out_last_o hold their values.
- R9: A run of 16 windows with every input at the most negative value (both parts) produces the exact mean without overflow.
- R10: After reset, in_ready_o is 1 and out_valid_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pts_log2_i | input | 4 | Window length exponent |
| avg_log2_i | input | 3 | Averaged window count exponent |
| in_valid_i | input | 1 | Input bin valid |
| in_ready_o | output | 1 | Input bin accepted when high with in_valid_i |
| in_re_i | input | 16 | Bin real part, signed |
| in_im_i | input | 16 | Bin imaginary part, signed |
| out_valid_o | output | 1 | Averaged bin valid |
| out_ready_i | input | 1 | Downstream ready |
| out_data_o | output | 33 | Averaged bin power |
| out_last_o | output | 1 | Final bin of the spectrum |

## Verification
The bench runs a single-window spectrum first, which isolates the squared-magnitude arithmetic. A four-window average on the same bins follows; a wrong overwrite of the first window would show up there as leftover power from the earlier run. Further runs cover a 128-bin window under random output stalls, which separates index stepping from data holding, and a run whose settings change after the first bin, which shows when the settings are sampled. Out-of-range exponents combined with full-scale negative inputs over 16 windows test clamping and accumulator width. A 1024-bin window tests the largest memory span, and input gaps are mixed into every run.

// File: rtl/psd_pkg.sv
package psd_pkg;
  typedef enum logic {
    ST_ACC = 1'b0,
    ST_OUT = 1'b1
  } psd_state_e;
endpackage

// File: rtl/psd_power.sv
module psd_power #(
  parameter int DATA_W = 16,
  parameter int PWR_W  = 2*DATA_W+1
) (
  input  logic signed [DATA_W-1:0] re_i,
  input  logic signed [DATA_W-1:0] im_i,
  output logic        [PWR_W-1:0]  pwr_o
);
  logic signed [2*DATA_W-1:0] re_sq, im_sq;
  logic        [2*DATA_W-1:0] re_u, im_u;

  always_comb begin
    re_sq = re_i * re_i;
    im_sq = im_i * im_i;
    re_u  = re_sq;
    im_u  = im_sq;
    pwr_o = PWR_W'(re_u) + PWR_W'(im_u);
  end
endmodule

// File: rtl/psd_bin_ram.sv
module psd_bin_ram #(
  parameter int AW = 10,
  parameter int DW = 37,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/psd_ctrl.sv
module psd_ctrl
  import psd_pkg::*;
#(
  parameter int MIN_PTS_LOG2 = 6,
  parameter int MAX_PTS_LOG2 = 10,
  parameter int MAX_AVG_LOG2 = 4,
  localparam int AW   = MAX_PTS_LOG2,
  localparam int PL_W = $clog2(MAX_PTS_LOG2+1),
  localparam int AL_W = $clog2(MAX_AVG_LOG2+1) < 1 ? 1 : $clog2(MAX_AVG_LOG2+1),
  localparam int WW   = MAX_AVG_LOG2 + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PL_W-1:0] pts_log2_i,
  input  logic [AL_W-1:0] avg_log2_i,
  input  logic            in_valid_i,
  output logic            in_ready_o,
  input  logic            out_ready_i,
  output logic            out_valid_o,
  output logic            out_last_o,
  output logic            acc_fire_o,
  output logic            first_win_o,
  output logic [AW-1:0]   acc_addr_o,
  output logic [AW-1:0]   rd_addr_o,
  output logic [AL_W-1:0] avg_sh_o
);
  psd_state_e      st_q;
  logic [AW-1:0]   bin_q, out_idx_q, last_idx;
  logic [WW-1:0]   win_q, navg;
  logic [PL_W-1:0] cfg_pts_q, pts_cl, eff_pts;
  logic [AL_W-1:0] cfg_avg_q, avg_cl, eff_avg;
  logic [AW:0]     npts;
  logic            out_vld_q, run_start, last_bin, last_win, fire, out_take;

  always_comb begin
    if (pts_log2_i < PL_W'(MIN_PTS_LOG2))      pts_cl = PL_W'(MIN_PTS_LOG2);
    else if (pts_log2_i > PL_W'(MAX_PTS_LOG2)) pts_cl = PL_W'(MAX_PTS_LOG2);
    else                                       pts_cl = pts_log2_i;
    avg_cl    = (avg_log2_i > AL_W'(MAX_AVG_LOG2)) ? AL_W'(MAX_AVG_LOG2) : avg_log2_i;
    run_start = (st_q == ST_ACC) && (bin_q == '0) && (win_q == '0);
    eff_pts   = run_start ? pts_cl : cfg_pts_q;
    eff_avg   = run_start ? avg_cl : cfg_avg_q;
    npts      = (AW+1)'(1) << eff_pts;
    last_idx  = AW'(npts - 1'b1);
    navg      = WW'(1) << eff_avg;
    last_bin  = (bin_q == last_idx);
    last_win  = (win_q == navg - 1'b1);
    fire      = in_valid_i && (st_q == ST_ACC);
    out_take  = out_vld_q && out_ready_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_ACC;
      bin_q     <= '0;
      win_q     <= '0;
      out_idx_q <= '0;
      out_vld_q <= 1'b0;
      cfg_pts_q <= PL_W'(MIN_PTS_LOG2);
      cfg_avg_q <= '0;
    end else if (st_q == ST_ACC) begin
      if (fire) begin
        if (run_start) begin
          cfg_pts_q <= pts_cl;
          cfg_avg_q <= avg_cl;
        end
        if (last_bin) begin
          bin_q <= '0;
          if (last_win) begin
            win_q     <= '0;
            st_q      <= ST_OUT;
            out_idx_q <= '0;
            out_vld_q <= 1'b0;
          end else begin
            win_q <= win_q + 1'b1;
          end
        end else begin
          bin_q <= bin_q + 1'b1;
        end
      end
    end else begin
      if (!out_vld_q) begin
        out_vld_q <= 1'b1;
      end else if (out_take) begin
        if (out_idx_q == last_idx) begin
          out_vld_q <= 1'b0;
          st_q      <= ST_ACC;
        end else begin
          out_idx_q <= out_idx_q + 1'b1;
        end
      end
    end
  end

  always_comb begin
    in_ready_o  = (st_q == ST_ACC);
    out_valid_o = out_vld_q;
    out_last_o  = out_vld_q && (out_idx_q == last_idx);
    acc_fire_o  = fire;
    first_win_o = (win_q == '0);
    acc_addr_o  = bin_q;
    avg_sh_o    = cfg_avg_q;
    if (st_q == ST_ACC)                           rd_addr_o = bin_q;
    else if (out_take && out_idx_q != last_idx)   rd_addr_o = out_idx_q + 1'b1;
    else                                          rd_addr_o = out_idx_q;
  end

  assert_phase_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_ready_o && out_valid_o));
  assert_out_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_idx_q) && $stable(out_last_o));
  assert_last_valid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |-> out_valid_o);
  assert_first_bin_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_vld_q) |-> out_idx_q == '0);
  assert_cfg_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_start && !$past(run_start) |-> $stable(cfg_pts_q) && $stable(cfg_avg_q));
endmodule

// File: rtl/psd_avg_accum.sv
module psd_avg_accum #(
  parameter int DATA_W       = 16,
  parameter int MIN_PTS_LOG2 = 6,
  parameter int MAX_PTS_LOG2 = 10,
  parameter int MAX_AVG_LOG2 = 4,
  localparam int PWR_W = 2*DATA_W + 1,
  localparam int ACC_W = PWR_W + MAX_AVG_LOG2,
  localparam int AW    = MAX_PTS_LOG2,
  localparam int PL_W  = $clog2(MAX_PTS_LOG2+1),
  localparam int AL_W  = $clog2(MAX_AVG_LOG2+1) < 1 ? 1 : $clog2(MAX_AVG_LOG2+1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [PL_W-1:0]          pts_log2_i,
  input  logic [AL_W-1:0]          avg_log2_i,
  input  logic                     in_valid_i,
  output logic                     in_ready_o,
  input  logic signed [DATA_W-1:0] in_re_i,
  input  logic signed [DATA_W-1:0] in_im_i,
  output logic                     out_valid_o,
  input  logic                     out_ready_i,
  output logic [PWR_W-1:0]         out_data_o,
  output logic                     out_last_o
);
  logic             acc_fire, first_win;
  logic [AW-1:0]    acc_addr, rd_addr;
  logic [AL_W-1:0]  avg_sh;
  logic [PWR_W-1:0] pwr;
  logic [ACC_W-1:0] rd_q, wdata;
  logic             p_vld_q, p_first_q;
  logic [AW-1:0]    p_addr_q;
  logic [PWR_W-1:0] p_pwr_q;
  logic [ACC_W:0]   sum_wide;

  psd_ctrl #(
    .MIN_PTS_LOG2(MIN_PTS_LOG2),
    .MAX_PTS_LOG2(MAX_PTS_LOG2),
    .MAX_AVG_LOG2(MAX_AVG_LOG2)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pts_log2_i (pts_log2_i),
    .avg_log2_i (avg_log2_i),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .out_ready_i(out_ready_i),
    .out_valid_o(out_valid_o),
    .out_last_o (out_last_o),
    .acc_fire_o (acc_fire),
    .first_win_o(first_win),
    .acc_addr_o (acc_addr),
    .rd_addr_o  (rd_addr),
    .avg_sh_o   (avg_sh)
  );

  psd_power #(.DATA_W(DATA_W), .PWR_W(PWR_W)) u_power (
    .re_i (in_re_i),
    .im_i (in_im_i),
    .pwr_o(pwr)
  );

  // second stage: stored sum arrives from the memory one cycle after the read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_vld_q   <= 1'b0;
      p_first_q <= 1'b0;
      p_addr_q  <= '0;
      p_pwr_q   <= '0;
    end else begin
      p_vld_q <= acc_fire;
      if (acc_fire) begin
        p_first_q <= first_win;
        p_addr_q  <= acc_addr;
        p_pwr_q   <= pwr;
      end
    end
  end

  always_comb begin
    sum_wide = (ACC_W+1)'(rd_q) + (ACC_W+1)'(p_pwr_q);
    wdata    = p_first_q ? ACC_W'(p_pwr_q) : ACC_W'(sum_wide);
  end

  psd_bin_ram #(.AW(AW), .DW(ACC_W)) u_ram (
    .clk_i  (clk_i),
    .we_i   (p_vld_q),
    .waddr_i(p_addr_q),
    .wdata_i(wdata),
    .raddr_i(rd_addr),
    .rdata_o(rd_q)
  );

  assign out_data_o = PWR_W'(rd_q >> avg_sh);

  assert_no_overflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p_vld_q && !p_first_q |-> !sum_wide[ACC_W]);
  assert_data_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> $stable(out_data_o));
  assert_no_write_out_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !p_vld_q);
endmodule

// File: tb/tb_psd_avg_accum.sv
module tb_psd_avg_accum;
  localparam int DATA_W = 16;
  localparam int PWR_W  = 2*DATA_W + 1;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [3:0]         pts_log2_i = 4'd6;
  logic [2:0]         avg_log2_i = 3'd0;
  logic               in_valid_i = 1'b0;
  logic               in_ready_o;
  logic signed [15:0] in_re_i = '0;
  logic signed [15:0] in_im_i = '0;
  logic               out_valid_o;
  logic               out_ready_i = 1'b1;
  logic [PWR_W-1:0]   out_data_o;
  logic               out_last_o;

  int     checks = 0;
  int     errors = 0;
  bit     bp_mode = 1'b0;
  bit     done = 1'b0;
  longint exp_q[$];
  bit     exp_last_q[$];

  always #2 clk = ~clk;

  psd_avg_accum dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .pts_log2_i (pts_log2_i),
    .avg_log2_i (avg_log2_i),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .in_re_i    (in_re_i),
    .in_im_i    (in_im_i),
    .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i),
    .out_data_o (out_data_o),
    .out_last_o (out_last_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // output side: random stalls, compare against the expected queue every clock
  initial begin
    logic [15:0] lfsr = 16'hACE1;
    bit          held = 1'b0;
    longint      held_data = 0;
    bit          held_last = 1'b0;
    wait (rst_n);
    forever begin
      @(negedge clk);
      if (held) begin
        chk(out_valid_o == 1'b1, "R8 valid held", longint'(out_valid_o), 1);
        chk(longint'(out_data_o) == held_data, "R8 data held", longint'(out_data_o), held_data);
        chk(out_last_o == held_last, "R8 last held", longint'(out_last_o), longint'(held_last));
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready_i = bp_mode ? lfsr[0] : 1'b1;
      held = 1'b0;
      if (out_valid_o) begin
        chk(in_ready_o == 1'b0, "R7 ready during drain", longint'(in_ready_o), 0);
        if (out_ready_i) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R7 unexpected output", longint'(out_data_o), -1);
          end else begin
            chk(longint'(out_data_o) == exp_q[0], "R3 averaged value", longint'(out_data_o), exp_q[0]);
            chk(out_last_o == exp_last_q[0], "R5 last flag", longint'(out_last_o), longint'(exp_last_q[0]));
            void'(exp_q.pop_front());
            void'(exp_last_q.pop_front());
          end
        end else begin
          held = 1'b1;
          held_data = longint'(out_data_o);
          held_last = out_last_o;
        end
      end
    end
  end

  // pts/avg: drive values; pts_alt/avg_alt: driven after first accepted bin
  task automatic run(input int pts, input int avg, input int seed,
                     input int pts_alt, input int avg_alt, input bit extreme);
    int ep = (pts < 6) ? 6 : (pts > 10) ? 10 : pts;
    int ea = (avg > 4) ? 4 : avg;
    int n  = 1 << ep;
    int nw = 1 << ea;
    int beat = 0;
    longint sums[] = new[n];
    pts_log2_i = pts[3:0];
    avg_log2_i = avg[2:0];
    for (int w = 0; w < nw; w++) begin
      for (int b = 0; b < n; b++) begin
        longint re, im;
        re = extreme ? -32768 : ((b*53 + w*97 + seed*31) % 8192) - 4096;
        im = extreme ? -32768 : ((b*29 + w*13 + seed*7) % 6000) - 3000;
        if (beat % 7 == 6) begin
          @(negedge clk);
          in_valid_i = 1'b0;
        end
        @(negedge clk);
        in_valid_i = 1'b1;
        in_re_i = 16'(re);
        in_im_i = 16'(im);
        while (!in_ready_o) @(negedge clk);
        @(posedge clk);
        beat++;
        if (w == 0 && b == 0) begin
          #1;
          pts_log2_i = pts_alt[3:0];
          avg_log2_i = avg_alt[2:0];
        end
        if (w == 0) sums[b] = re*re + im*im;
        else        sums[b] += re*re + im*im;
      end
    end
    for (int b = 0; b < n; b++) begin
      exp_q.push_back(sums[b] >>> ea);
      exp_last_q.push_back(b == n-1);
    end
    @(negedge clk);
    in_valid_i = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready_o == 1'b1, "R10 ready after reset", longint'(in_ready_o), 1);
    chk(out_valid_o == 1'b0, "R10 valid after reset", longint'(out_valid_o), 0);
    run(6, 0, 1, 6, 0, 0);      // R1 R2 single window
    run(6, 2, 2, 6, 2, 0);      // R3 R4 four windows over stale memory
    bp_mode = 1'b1;
    run(7, 1, 3, 7, 1, 0);      // R8 R5 128 bins with stalls
    run(6, 2, 4, 8, 0, 0);      // R6 settings changed mid-run
    run(3, 7, 5, 3, 7, 1);      // R2 R3 R9 clamped, full-scale negative
    bp_mode = 1'b0;
    run(10, 0, 6, 10, 0, 0);    // R2 largest window
    run(6, 1, 7, 6, 1, 0);      // R4 after large run
    chk(exp_q.size() == 0, "R5 all bins delivered", longint'(exp_q.size()), 0);
    @(negedge clk);
    chk(in_ready_o == 1'b1, "R7 ready after drain", longint'(in_ready_o), 1);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R5 watchdog actual=%0d expected=%0d", exp_q.size(), 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule